// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates the five maskable interrupt sources of a small 8-bit microcontroller core. The sources are two external pins, two timer overflow flags and one serial flag (receive or transmit). Each source has its own enable bit, and one global enable gates all of them. A one-bit priority per source places it at the low or the high level. Inside a level, a fixed polling order breaks ties, so every source always has a unique rank. The winner is offered to the core as a request strobe with a vector address.

The core accepts a request by pulsing an acknowledge. At that point the block records the service level in a two-entry in-service stack. On the same acknowledge it clears the external edge flag or asks the timer to drop its overflow flag. A return pulse from the core pops the stack. A high-level request may interrupt a low-level service. Nothing interrupts a high-level service. Each external pin is synchronized and can work as a low-level request or as a latched falling-edge request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held and after it is released, `irq_req` is 0, `irq_vec` is 0x0000 (the reset start address), and `tf_clr` is 0.
- R2: A source can request only when its enable bit is set and the global enable is set. A write with `cfg_addr`=0 loads the enable bits from `cfg_wdata[4:0]` (bit i for source index i) and the global enable from `cfg_wdata[7]`.
- R3: Source indices in polling order are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. The vector is 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: When every priority bit is 0, the eligible source with the lowest index wins.
- R5: A write with `cfg_addr`=2'd1 loads the priority bits from `cfg_wdata[4:0]`. A 1 puts the source at the high level. An eligible high-level source beats every low-level source. Within a level, the lowest index wins.
- R6: A request is taken when `irq_ack` is high while `irq_req` is high. In the cycle after a take, `irq_req` is 0. The taken level is then in service, and while it stays in service no source of the same level can request.
- R7: While only a low-level service is active, a high-level source still requests. While a high-level service is active, no source requests.
- R8: A pulse on `irq_reti` ends the high-level service if one is active, and otherwise ends the low-level service.
- R9: A write with `cfg_addr`=2'd2 sets the trigger mode from `cfg_wdata[1:0]`: bit 0 controls external 0 and bit 1 controls external 1, with 1 meaning edge mode. In edge mode, a falling edge on the synchronized pin latches a request. The request stays after the pin returns high, and a take of that source clears it.
- R10: In level mode, an external source requests while its synchronized pin is low and stops when the pin returns high. Nothing is latched, and any latched edge request is discarded.
- R11: During the take cycle of timer 0 or timer 1, `tf_clr[0]` or `tf_clr[1]` is high, respectively. It is 0 in every other case, including takes of other sources.
- R12: The serial source requests while `ser_ri` or `ser_ti` is high. Its flags are never cleared by the block, so a held flag requests again after `irq_reti`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 enable, 1 priority, 2 trigger mode |
| cfg_wdata | input | 8 | Configuration write data |
| ext_n | input | 2 | External request pins, active low, asynchronous |
| tf_in | input | 2 | Timer overflow flags |
| ser_ri | input | 1 | Serial receive flag |
| ser_ti | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_reti | input | 1 | Core returns from the current service |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the offered request |
| tf_clr | output | 2 | Overflow flag clear pulses for the timers |

## Verification
The arbiter is driven with sets of simultaneous pending sources under all-zero, single-bit and multi-bit priority masks. These show whether the polling order or the level decides the winner. Nested takes at low then high level, followed by returns, tell preemption apart from same-level blocking and show which stack entry a return pops. Short pulses on the pins in both trigger modes separate latched edge requests from level requests. Long random sequences of configuration writes, flag changes, takes and returns are then compared with a reference model of the requirements.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int AW       = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic [1:0]    ext_n,
  input  logic [1:0]    tf_in,
  input  logic          ser_ri,
  input  logic          ser_ti,
  input  logic          irq_ack,
  input  logic          irq_reti,
  output logic          irq_req,
  output logic [AW-1:0] irq_vec,
  output logic [1:0]    tf_clr
);
  localparam int NSRC = 5;
  localparam int IDW  = $clog2(NSRC);

  logic [NSRC-1:0] en_q, pri_q;
  logic            ea_q;
  logic [1:0]      edge_q;
  logic [1:0]      s1, s2, s3, eflag, ext_req;
  logic [1:0]      isr_q, isr_n;
  logic            req_q, lvl_q;
  logic [IDW-1:0]  id_q, win;
  logic [AW-1:0]   vec_q;
  logic [NSRC-1:0] pend, elig, hi, cand;
  logic            take;

  assign take = irq_ack & req_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0; ea_q <= 1'b0; pri_q <= '0; edge_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin en_q <= cfg_wdata[NSRC-1:0]; ea_q <= cfg_wdata[7]; end
        2'd1: pri_q  <= cfg_wdata[NSRC-1:0];
        2'd2: edge_q <= cfg_wdata[1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
    end else begin
      s1 <= ext_n; s2 <= s1; s3 <= s2;
    end

  for (genvar i = 0; i < 2; i++) begin : g_ext
    localparam logic [IDW-1:0] EID = IDW'(2 * i);
    localparam logic [IDW-1:0] TID = IDW'(2 * i + 1);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      eflag[i] <= 1'b0;
      else if (!edge_q[i])             eflag[i] <= 1'b0;
      else if (s3[i] && !s2[i])        eflag[i] <= 1'b1;
      else if (take && id_q == EID)    eflag[i] <= 1'b0;
    assign ext_req[i] = edge_q[i] ? eflag[i] : ~s2[i];
    assign tf_clr[i]  = take && (id_q == TID);
  end

  assign pend = {ser_ri | ser_ti, tf_in[1], ext_req[1], tf_in[0], ext_req[0]};

  always_comb begin
    elig = pend & en_q & {NSRC{ea_q}};
    if (isr_q[1])      elig = '0;
    else if (isr_q[0]) elig = elig & pri_q;
    hi   = elig & pri_q;
    cand = (|hi) ? hi : elig;
    win  = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i]) win = IDW'(i);
  end

  always_comb begin
    isr_n = isr_q;
    if (irq_reti) begin
      if (isr_n[1]) isr_n[1] = 1'b0;
      else          isr_n[0] = 1'b0;
    end
    if (take) isr_n[lvl_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      isr_q <= '0; req_q <= 1'b0; id_q <= '0; lvl_q <= 1'b0; vec_q <= '0;
    end else begin
      isr_q <= isr_n;
      req_q <= ~take & (|elig);
      if (|elig) begin
        id_q  <= win;
        lvl_q <= pri_q[win];
        vec_q <= AW'(VEC_BASE) + AW'(win) * AW'(VEC_STEP);
      end
    end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req,
  input logic          irq_ack,
  input logic [AW-1:0] irq_vec,
  input logic [1:0]    tf_clr,
  input logic          ea_q,
  input logic [1:0]    isr_q
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> !irq_req && tf_clr == 2'b00);
  p_global_gate_r2: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> $past(ea_q));
  p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= AW'(16'h0023)));
  p_drop_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n) irq_req && irq_ack |=> !irq_req);
  p_high_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n) isr_q[1] |-> !irq_req);
  p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tf_clr));
  p_clr_on_take_r11: assert property (@(posedge clk) disable iff (!rst_n) tf_clr != 2'b00 |-> irq_ack && irq_req);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .irq_vec(irq_vec), .tf_clr(tf_clr), .ea_q(ea_q), .isr_q(isr_q)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] ext_n = 2'b11, tf_in = 2'b00;
  logic ser_ri = 1'b0, ser_ti = 1'b0, irq_ack = 1'b0, irq_reti = 1'b0;
  logic irq_req;
  logic [15:0] irq_vec;
  logic [1:0] tf_clr;

  int tests = 0, fails = 0;
  logic [4:0] m_en = '0, m_pri = '0;
  logic m_ea = 1'b0;
  logic [1:0] m_edge = '0, m_ef = '0, m_isr = '0;

  irq_prio_ctrl dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic int exp_win();
    logic [4:0] p, e;
    p[0] = m_edge[0] ? m_ef[0] : !ext_n[0];
    p[1] = tf_in[0];
    p[2] = m_edge[1] ? m_ef[1] : !ext_n[1];
    p[3] = tf_in[1];
    p[4] = ser_ri | ser_ti;
    e = p & m_en & {5{m_ea}};
    if (m_isr[1]) e = '0;
    else if (m_isr[0]) e = e & m_pri;
    for (int i = 0; i < 5; i++) if (e[i] && m_pri[i]) return i;
    for (int i = 0; i < 5; i++) if (e[i]) return i;
    return -1;
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_out(input string r, input int req, input int vec);
    settle();
    chk(r, irq_req, req);
    if (req != 0) chk(r, irq_vec, vec);
  endtask

  task automatic model_check(input string r);
    int w;
    settle();
    w = exp_win();
    chk(r, irq_req, (w >= 0) ? 1 : 0);
    if (w >= 0) chk(r, irq_vec, 3 + 8 * w);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: begin m_en = d[4:0]; m_ea = d[7]; end
      2'd1: m_pri = d[4:0];
      2'd2: begin m_edge = d[1:0]; m_ef = m_ef & m_edge; end
      default: ;
    endcase
  endtask

  task automatic set_pin(input int i, input logic v);
    if (ext_n[i] && !v && m_edge[i]) m_ef[i] = 1'b1;
    ext_n[i] = v;
  endtask

  task automatic do_ack();
    int w;
    logic [1:0] ec;
    w = exp_win();
    irq_ack = 1'b1;
    #1;
    ec = (w == 1) ? 2'b01 : (w == 3) ? 2'b10 : 2'b00;
    chk("R11 tf_clr during take", tf_clr, ec);
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R6 request drops after take", irq_req, 0);
    if (w >= 0) m_isr[m_pri[w]] = 1'b1;
    if (w == 1) tf_in[0] = 1'b0;
    if (w == 3) tf_in[1] = 1'b0;
    if (w == 0) m_ef[0] = 1'b0;
    if (w == 2) m_ef[1] = 1'b0;
  endtask

  task automatic do_reti();
    irq_reti = 1'b1;
    @(negedge clk);
    irq_reti = 1'b0;
    if (m_isr[1]) m_isr[1] = 1'b0;
    else m_isr[0] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 req in reset", irq_req, 0);
    chk("R1 vec in reset", irq_vec, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", irq_req, 0);
    chk("R1 vec after reset", irq_vec, 16'h0000);
    chk("R1 tf_clr after reset", tf_clr, 0);

    tf_in = 2'b01;
    expect_out("R2 source disabled", 0, 0);
    wr(2'd0, 8'h02);
    expect_out("R2 global enable clear", 0, 0);
    wr(2'd0, 8'h82);
    expect_out("R3 timer0 vector", 1, 16'h000B);

    wr(2'd0, 8'h9F);
    ser_ri = 1'b1; tf_in = 2'b11; ext_n = 2'b00;
    expect_out("R4 polling order winner", 1, 16'h0003);
    wr(2'd1, 8'h10);
    expect_out("R5 serial at high level", 1, 16'h0023);
    wr(2'd1, 8'h18);
    expect_out("R5 tie at high level", 1, 16'h001B);

    wr(2'd1, 8'h00);
    settle();
    do_ack();
    expect_out("R6 same level blocked", 0, 0);
    wr(2'd1, 8'h08);
    expect_out("R7 high preempts low", 1, 16'h001B);
    do_ack();
    wr(2'd1, 8'h1F);
    expect_out("R7 high service blocks all", 0, 0);
    do_reti();
    expect_out("R8 return pops high first", 1, 16'h0003);
    wr(2'd1, 8'h00);
    expect_out("R8 low still in service", 0, 0);
    do_reti();
    expect_out("R8 return pops low", 1, 16'h0003);

    ext_n = 2'b11; tf_in = 2'b00; ser_ri = 1'b0;
    wr(2'd0, 8'h81);
    expect_out("R10 idle pin", 0, 0);
    set_pin(0, 1'b0);
    expect_out("R10 level low requests", 1, 16'h0003);
    set_pin(0, 1'b1);
    expect_out("R10 level not latched", 0, 0);
    wr(2'd2, 8'h01);
    set_pin(0, 1'b0);
    settle();
    set_pin(0, 1'b1);
    expect_out("R9 edge latched", 1, 16'h0003);
    do_ack();
    do_reti();
    expect_out("R9 edge flag cleared by take", 0, 0);

    wr(2'd0, 8'h90);
    ser_ti = 1'b1;
    expect_out("R12 serial transmit requests", 1, 16'h0023);
    do_ack();
    do_reti();
    expect_out("R12 serial requests again", 1, 16'h0023);
    ser_ti = 1'b0;
    expect_out("R12 serial flags low", 0, 0);

    for (int n = 0; n < 600; n++) begin
      logic [7:0] d;
      int act;
      act = int'($urandom % 8);
      d = 8'($urandom);
      case (act)
        0: begin d[7] = ($urandom % 4) != 0; wr(2'd0, d); end
        1: wr(2'd1, d);
        2: wr(2'd2, d);
        3: set_pin(int'($urandom % 2), 1'($urandom));
        4: tf_in[$urandom % 2] = 1'b1;
        5: begin ser_ri = 1'($urandom); ser_ti = ($urandom % 3) == 0; end
        6: if (exp_win() >= 0) do_ack();
        default: if (m_isr != 2'b00) do_reti();
      endcase
      model_check("R5 random arbitration");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule